// File: doc/BRIEF.md
# Sensor event and attention controller

This block sits between a single-wire slave interface and a sensing function. It keeps the latest sensor result, the status flags that describe it, and the rule set that decides when the slave asks the line driver to put an attention request on the bus. A new result arrives as a one-cycle strobe with a 10-bit value. The block places that value in a 16-bit readout register and raises an event flag. If the previous result was never read, it also raises an overrun flag. A bus-error strobe from the line interface raises a third flag. Read strobes from the register decoder clear these flags.

Attention requests come from two sources. Function events (new results) only request attention while sensing and attention are both enabled. Once any attention request has been seen on the bus, further function requests are dropped until the status register is read or the bus is reset. Bus-error requests ignore that lockout, but a bus reset cancels them. After any bus reset, including the power-on reset, nothing is requested until the master has clocked 14 data bits. A request that is armed waits until the line interface reports an idle bus. It then leaves the block as a single-cycle pulse.

A conversion-interval timer counts an external millisecond tick and emits a start strobe for the converter stimulus. Its period comes from a 2-bit rate code and a low-power bit held in a small control register. The timer restarts whenever either field changes, and it stops while the run bit is clear.

Top module: `sevt_attn_ctrl`

## Requirements
- R1: On a result strobe, `result_q[15:6]` takes the 10-bit two's-complement value and `result_q[5:0]` reads 0, visible the cycle after the strobe.
- R2: A result strobe sets the event flag (`status_q[0]`). A `rd_result` strobe without a simultaneous result clears both the event flag and the overrun flag.
- R3: A result strobe that arrives while the event flag is set, and with no `rd_result` in the same cycle, overwrites the readout register and sets the overrun flag (`status_q[4]`).
- R4: `status_q` holds the bus-error flag in bit 7, the overrun flag in bit 4 and the event flag in bit 0, and all other bits read 0. `bus_err` sets bit 7, and `rd_status` clears it.
- R5: A function event arms an attention request only while control bit 0 (run) and control bit 1 (attention enable) are both 1. An armed request is issued as a one-cycle `attn_req` pulse on the cycle after `bus_idle` is seen high, and it waits for as long as the bus is busy.
- R6: After an attention request has been issued by this block, or reported on the bus by `attn_seen`, further function-event requests are discarded until `rd_status` or `bus_reset`.
- R7: A bus error arms an attention request that is issued even while the function lockout of R6 is active. A `bus_reset` that occurs before the request is issued cancels it.
- R8: After `rst_n` or `bus_reset`, no `attn_req` is issued until 14 `data_bit` strobes have been counted. A request that is still pending is issued once that count is reached.
- R9: With run set and a tick on every cycle, `conv_start` pulses every 14, 91, 182 or 364 ticks for rate codes 0 to 3 (control bits 3:2) with control bit 4 (low power) clear. With the low-power bit set, the periods are 91, 364, 728 or 1456 ticks.
- R10: A change of the rate code or the low-power bit restarts the interval, so the first `conv_start` comes period+1 cycles after the write edge. With run clear, no `conv_start` is produced.
- R11: The control register resets to 8'h08 (rate code 2, all other fields 0). A write keeps only bits 4:0, and bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also treated as a bus reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [0] run, [1] attention enable, [3:2] rate, [4] low power |
| ctl_q | output | 8 | Control register contents |
| conv_start | output | 1 | One-cycle conversion start strobe |
| res_valid | input | 1 | New result strobe from the converter stimulus |
| res_data | input | 10 | Result, two's complement, 0.25 degree steps |
| rd_result | input | 1 | Readout register read strobe |
| rd_status | input | 1 | Status register read strobe |
| result_q | output | 16 | Left-aligned readout register |
| status_q | output | 8 | Status flags |
| bus_idle | input | 1 | Line interface reports an idle bus |
| bus_reset | input | 1 | Bus reset detected |
| data_bit | input | 1 | One data bit seen on the bus |
| attn_seen | input | 1 | Attention request observed on the bus |
| bus_err | input | 1 | Bus error detected by the line interface |
| attn_req | output | 1 | Attention request pulse to the line interface |

## Verification
The readout register and every status flag change on the edge that samples their strobe, so the bench checks them on the falling edge after that strobe. An armed attention request takes one edge to register, and the pulse appears on the cycle after the first idle, unblocked edge. The bench counts pulses on a monitor and compares the count several cycles after each stimulus, so a pulse that is one cycle early or late still lands inside the window, but a missing or extra pulse is caught. Timer periods are measured as the number of falling edges between consecutive `conv_start` pulses. After a control write, the restart latency is counted as period+1 edges, because the change is registered once before the count begins.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
   localparam int RES_W      = 10;
   localparam int REG_W      = 16;
   localparam int STAT_W     = 8;
   localparam int CTL_W      = 8;
   localparam int BER_BIT    = 7;
   localparam int OVR_BIT    = 4;
   localparam int EVT_BIT    = 0;
   localparam int LOCK_BITS  = 14;
   localparam int MAX_PERIOD = 1456;
   localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

   typedef struct packed {
      logic       lp;
      logic [1:0] rate;
      logic       aen;
      logic       run;
   } ctl_t;

   localparam int CTL_USED = $bits(ctl_t);

   // interval length in ticks for a power mode and rate code
   function automatic int unsigned period_ms(input logic lp, input logic [1:0] rate);
      int unsigned base;
      case (rate)
         2'd0:    base = lp ? 91  : 14;
         2'd1:    base = lp ? 364 : 91;
         2'd2:    base = lp ? 728 : 182;
         default: base = lp ? 1456 : 364;
      endcase
      return base;
   endfunction
endpackage

// File: rtl/sevt_conv_timer.sv
module sevt_conv_timer
   import sevt_pkg::*;
#(
   parameter int CW = CNT_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       run,
   input  logic       lp,
   input  logic [1:0] rate,
   output logic       conv_start
);
   if (MAX_PERIOD >= (1 << CW)) begin : g_bad_width
      $error("sevt_conv_timer: counter too narrow for longest interval");
   end

   logic [2:0]    mode_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] period;
   logic          mode_chg;

   assign period   = CW'(period_ms(lp, rate));
   assign mode_chg = ({lp, rate} != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 3'b010;
         cnt_q      <= '0;
         conv_start <= 1'b0;
      end else begin
         mode_q     <= {lp, rate};
         conv_start <= 1'b0;
         if (!run || mode_chg) begin
            cnt_q <= '0;
         end else if (ms_tick) begin
            if (cnt_q == period - 1'b1) begin
               cnt_q      <= '0;
               conv_start <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sevt_result_flags.sv
module sevt_result_flags #(
   parameter int RW = 10,
   parameter int GW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          res_valid,
   input  logic [RW-1:0] res_data,
   input  logic          rd_result,
   input  logic          rd_status,
   input  logic          bus_err,
   output logic [GW-1:0] result_q,
   output logic          evt_q,
   output logic          ovr_q,
   output logic          ber_q
);
   if (GW < RW) begin : g_bad_width
      $error("sevt_result_flags: register narrower than result");
   end

   logic [RW-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         evt_q <= 1'b0;
         ovr_q <= 1'b0;
         ber_q <= 1'b0;
      end else begin
         if (res_valid) begin
            val_q <= res_data;
            evt_q <= 1'b1;
         end else if (rd_result) begin
            evt_q <= 1'b0;
         end

         if (res_valid && evt_q && !rd_result) begin
            ovr_q <= 1'b1;
         end else if (rd_result) begin
            ovr_q <= 1'b0;
         end

         if (bus_err) begin
            ber_q <= 1'b1;
         end else if (rd_status) begin
            ber_q <= 1'b0;
         end
      end
   end

   // left alignment: the value occupies the top bits, padding is zero
   if (GW > RW) begin : g_pad
      assign result_q = {val_q, {(GW-RW){1'b0}}};
   end else begin : g_exact
      assign result_q = val_q;
   end
endmodule

// File: rtl/sevt_attn_arb.sv
module sevt_attn_arb #(
   parameter int NBITS = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fn_event,
   input  logic bus_err,
   input  logic bus_reset,
   input  logic bus_idle,
   input  logic data_bit,
   input  logic attn_seen,
   input  logic rd_status,
   output logic attn_req
);
   localparam int LCW = $clog2(NBITS + 1);

   if (NBITS < 1) begin : g_bad_count
      $error("sevt_attn_arb: bit count after reset must be positive");
   end

   logic [LCW-1:0] bit_cnt_q;
   logic           blocked;
   logic           go;
   logic           fire;
   logic           fn_pend_q;
   logic           ber_pend_q;
   logic           lock_q;

   assign blocked = (bit_cnt_q < LCW'(NBITS));
   assign go      = bus_idle && !blocked && !bus_reset;
   assign fire    = go && ((fn_pend_q && !lock_q) || ber_pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q  <= '0;
         fn_pend_q  <= 1'b0;
         ber_pend_q <= 1'b0;
         lock_q     <= 1'b0;
         attn_req   <= 1'b0;
      end else begin
         attn_req <= fire;

         if (bus_reset) begin
            bit_cnt_q <= '0;
         end else if (data_bit && blocked) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
         end

         // a function request is consumed at the first usable idle:
         // sent when unlocked, discarded when locked
         if (fn_event) begin
            fn_pend_q <= 1'b1;
         end else if (go) begin
            fn_pend_q <= 1'b0;
         end

         if (bus_err) begin
            ber_pend_q <= 1'b1;
         end else if (bus_reset || fire) begin
            ber_pend_q <= 1'b0;
         end

         if (bus_reset || rd_status) begin
            lock_q <= 1'b0;
         end else if (attn_seen || fire) begin
            lock_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sevt_attn_ctrl.sv
module sevt_attn_ctrl
   import sevt_pkg::*;
#(
   parameter int RES_BITS = RES_W,
   parameter int REG_BITS = REG_W,
   parameter int RST_BITS = LOCK_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ms_tick,
   input  logic                ctl_we,
   input  logic [CTL_W-1:0]    ctl_wdata,
   output logic [CTL_W-1:0]    ctl_q,
   output logic                conv_start,
   input  logic                res_valid,
   input  logic [RES_BITS-1:0] res_data,
   input  logic                rd_result,
   input  logic                rd_status,
   output logic [REG_BITS-1:0] result_q,
   output logic [STAT_W-1:0]   status_q,
   input  logic                bus_idle,
   input  logic                bus_reset,
   input  logic                data_bit,
   input  logic                attn_seen,
   input  logic                bus_err,
   output logic                attn_req
);
   if (CTL_W < CTL_USED) begin : g_bad_ctl
      $error("sevt_attn_ctrl: control width too small for its fields");
   end

   ctl_t ctl_r;
   logic evt_q, ovr_q, ber_q;
   logic fn_event;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_r <= '{lp: 1'b0, rate: 2'b10, aen: 1'b0, run: 1'b0};
      end else if (ctl_we) begin
         ctl_r <= ctl_t'(ctl_wdata[CTL_USED-1:0]);
      end
   end

   assign ctl_q    = {{(CTL_W-CTL_USED){1'b0}}, ctl_r};
   assign fn_event = res_valid && ctl_r.run && ctl_r.aen;

   always_comb begin
      status_q          = '0;
      status_q[BER_BIT] = ber_q;
      status_q[OVR_BIT] = ovr_q;
      status_q[EVT_BIT] = evt_q;
   end

   sevt_conv_timer #(.CW(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .run        (ctl_r.run),
      .lp         (ctl_r.lp),
      .rate       (ctl_r.rate),
      .conv_start (conv_start)
   );

   sevt_result_flags #(.RW(RES_BITS), .GW(REG_BITS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_data  (res_data),
      .rd_result (rd_result),
      .rd_status (rd_status),
      .bus_err   (bus_err),
      .result_q  (result_q),
      .evt_q     (evt_q),
      .ovr_q     (ovr_q),
      .ber_q     (ber_q)
   );

   sevt_attn_arb #(.NBITS(RST_BITS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .fn_event  (fn_event),
      .bus_err   (bus_err),
      .bus_reset (bus_reset),
      .bus_idle  (bus_idle),
      .data_bit  (data_bit),
      .attn_seen (attn_seen),
      .rd_status (rd_status),
      .attn_req  (attn_req)
   );
endmodule

// File: rtl/sevt_attn_ctrl_chk.sv
module sevt_attn_ctrl_chk #(
   parameter int RB = 10,
   parameter int GB = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    ctl_q,
   input logic          conv_start,
   input logic          res_valid,
   input logic [RB-1:0] res_data,
   input logic          rd_result,
   input logic          rd_status,
   input logic [GB-1:0] result_q,
   input logic [7:0]    status_q,
   input logic          bus_idle,
   input logic          bus_reset,
   input logic          bus_err,
   input logic          attn_req
);
   p_res_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (result_q[GB-1 -: RB] == $past(res_data)) && (result_q[GB-RB-1:0] == '0));

   p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> status_q[0]);

   p_rd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_result && !res_valid) |=> (!status_q[0] && !status_q[4]));

   p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && status_q[0] && !rd_result) |=> status_q[4]);

   p_ber_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !bus_err) |=> !status_q[7]);

   p_attn_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      attn_req |-> $past(bus_idle));

   p_no_attn_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !attn_req);

   p_conv_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(ctl_q[0]));
endmodule

bind sevt_attn_ctrl sevt_attn_ctrl_chk #(.RB(RES_BITS), .GB(REG_BITS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_q      (ctl_q),
   .conv_start (conv_start),
   .res_valid  (res_valid),
   .res_data   (res_data),
   .rd_result  (rd_result),
   .rd_status  (rd_status),
   .result_q   (result_q),
   .status_q   (status_q),
   .bus_idle   (bus_idle),
   .bus_reset  (bus_reset),
   .bus_err    (bus_err),
   .attn_req   (attn_req)
);

// File: tb/sevt_attn_ctrl_tb.sv
`timescale 1ns/1ps
module sevt_attn_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b1;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_q;
   logic        conv_start;
   logic        res_valid = 1'b0;
   logic [9:0]  res_data = '0;
   logic        rd_result = 1'b0;
   logic        rd_status = 1'b0;
   logic [15:0] result_q;
   logic [7:0]  status_q;
   logic        bus_idle = 1'b1;
   logic        bus_reset = 1'b0;
   logic        data_bit = 1'b0;
   logic        attn_seen = 1'b0;
   logic        bus_err = 1'b0;
   logic        attn_req;

   int n_total = 0;
   int n_fail  = 0;
   int attn_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sevt_attn_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .conv_start(conv_start),
      .res_valid(res_valid), .res_data(res_data), .rd_result(rd_result),
      .rd_status(rd_status), .result_q(result_q), .status_q(status_q),
      .bus_idle(bus_idle), .bus_reset(bus_reset), .data_bit(data_bit),
      .attn_seen(attn_seen), .bus_err(bus_err), .attn_req(attn_req)
   );

   always @(posedge clk) if (rst_n && attn_req) attn_cnt <= attn_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic put_res(input logic [9:0] v);
      @(negedge clk); res_valid = 1'b1; res_data = v;
      @(negedge clk); res_valid = 1'b0;
   endtask

   task automatic read_status();
      @(negedge clk); rd_status = 1'b1;
      @(negedge clk); rd_status = 1'b0;
   endtask

   task automatic read_result();
      @(negedge clk); rd_result = 1'b1;
      @(negedge clk); rd_result = 1'b0;
   endtask

   task automatic send_bits(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); data_bit = 1'b1;
         @(negedge clk); data_bit = 1'b0;
      end
   endtask

   task automatic pulse_err();
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
   endtask

   task automatic pulse_breset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   task automatic pulse_seen();
      @(negedge clk); attn_seen = 1'b1;
      @(negedge clk); attn_seen = 1'b0;
   endtask

   // falling edges between two consecutive conversion strobes
   task automatic measure_gap(output int gap);
      int lim = 0;
      do begin @(negedge clk); lim++; end while (!conv_start && lim < 3000);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!conv_start && gap < 3000);
   endtask

   task automatic t_reset();
      chk("R11 ctl reset", ctl_q, 8'h08);
      chk("R4 status reset", status_q, 8'h00);
      chk("R1 result reset", result_q, 16'h0000);
      chk("R5 no attn at reset", attn_req, 1'b0);
   endtask

   task automatic t_ctl_r11();
      wr_ctl(8'hEB);
      chk("R11 upper bits dropped", ctl_q, 8'h0B);
   endtask

   task automatic t_block_r8();
      put_res(10'h001);
      idle(10);
      chk("R8 blocked before bits", attn_cnt, 0);
      send_bits(13);
      idle(4);
      chk("R8 blocked after 13 bits", attn_cnt, 0);
      send_bits(1);
      idle(4);
      chk("R8 released after 14 bits", attn_cnt, 1);
      read_status();
      read_result();
   endtask

   task automatic t_result();
      put_res(10'h2A5);
      chk("R1 left aligned", result_q, 16'hA940);
      chk("R2 event set", status_q, 8'h01);
      put_res(10'h3FF);
      chk("R1 negative value", result_q, 16'hFFC0);
      chk("R3 overrun set", status_q, 8'h11);
      read_result();
      chk("R2 read clears flags", status_q, 8'h00);
      chk("R2 result kept", result_q, 16'hFFC0);
      put_res(10'h100);
      read_result();
      chk("R3 no overrun when read", status_q, 8'h00);
      read_status();
   endtask

   task automatic t_lock_r6();
      int base;
      base = attn_cnt;
      put_res(10'h010);
      idle(4);
      chk("R6 first event requests", attn_cnt, base + 1);
      put_res(10'h011);
      idle(4);
      chk("R6 locked after own request", attn_cnt, base + 1);
      read_status();
      pulse_seen();
      put_res(10'h012);
      idle(4);
      chk("R6 locked by foreign request", attn_cnt, base + 1);
      read_status();
      put_res(10'h013);
      idle(4);
      chk("R6 status read unlocks", attn_cnt, base + 2);
      read_result();
      read_status();
   endtask

   task automatic t_gate_r5();
      int base;
      base = attn_cnt;
      wr_ctl(8'h09);
      put_res(10'h020);
      idle(4);
      chk("R5 attention disabled", attn_cnt, base);
      wr_ctl(8'h0A);
      put_res(10'h021);
      idle(4);
      chk("R5 run cleared", attn_cnt, base);
      wr_ctl(8'h0B);
      @(negedge clk); bus_idle = 1'b0;
      put_res(10'h022);
      idle(10);
      chk("R5 waits for idle", attn_cnt, base);
      @(negedge clk); bus_idle = 1'b1;
      idle(4);
      chk("R5 issued on idle", attn_cnt, base + 1);
      read_result();
      read_status();
   endtask

   task automatic t_ber_r7();
      int base;
      put_res(10'h030);
      idle(4);
      read_result();
      base = attn_cnt;
      pulse_err();
      chk("R4 error flag set", status_q, 8'h80);
      idle(4);
      chk("R7 error request despite lock", attn_cnt, base + 1);
      read_status();
      chk("R4 status read clears error", status_q, 8'h00);
      @(negedge clk); bus_idle = 1'b0;
      pulse_err();
      pulse_breset();
      @(negedge clk); bus_idle = 1'b1;
      send_bits(14);
      idle(4);
      chk("R7 reset cancels error request", attn_cnt, base + 1);
      read_status();
   endtask

   task automatic t_timer_r9();
      int g;
      wr_ctl(8'h03);
      measure_gap(g); chk("R9 rate0 active", g, 14);
      wr_ctl(8'h07);
      measure_gap(g); chk("R9 rate1 active", g, 91);
      wr_ctl(8'h0F);
      measure_gap(g); chk("R9 rate3 active", g, 364);
      wr_ctl(8'h13);
      measure_gap(g); chk("R9 rate0 low power", g, 91);
      wr_ctl(8'h1F);
      measure_gap(g); chk("R9 rate3 low power", g, 1456);
   endtask

   task automatic t_restart_r10();
      int n;
      int seen;
      wr_ctl(8'h03);
      idle(30);
      wr_ctl(8'h07);
      n = 0;
      do begin @(negedge clk); n++; end while (!conv_start && n < 3000);
      chk("R10 restart on rate change", n, 92);
      wr_ctl(8'h02);
      idle(2);
      seen = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (conv_start) seen++;
      end
      chk("R10 shutdown stops timer", seen, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_total++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_r11();
      t_block_r8();
      t_result();
      t_lock_r6();
      t_gate_r5();
      t_ber_r7();
      t_timer_r9();
      t_restart_r10();
      finished = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule